// File: doc/BRIEF.md
# Two-Wire Edge-Counting Shift Unit

This block is the bit-level engine of a two-wire serial bus controller. A sequencer elsewhere on the chip loads a byte into an internal shift register. It then presets a small edge counter and issues clock-toggle strobes. Each strobe inverts the unit's SCL drive, and each resulting bus edge advances the counter. When the counter wraps past its top value, the overflow flag marks the end of the transfer. Presetting the counter to zero gives a full byte of 16 edges. A preset of 14 gives a single bit of 2 edges, which is how acknowledge bits are sent or received.

Both bus lines are open-drain. The unit only ever pulls a line low, and it reads the resolved line levels back on its inputs. The SDA drive follows the top bit of the shift register, so a register holding all ones leaves SDA released. Data shifts in from the bus one bit per SCL period. On the same wires the unit watches for start and stop conditions and for a released SDA that another device holds low. It records each of these in a sticky flag. Every flag is cleared by writing a one to its mask position in the status write. That same write also presets the counter.

Top module: `tws_shift_unit`

## Requirements
- R1: After reset both lines are released (`sclDrvLow`=0, `sdaDrvLow`=0), `dataOut` is 0xFF, `cntOut` is 0 and all four flags are 0.
- R2: A cycle with `strobe` high inverts `sclDrvLow` on the next clock edge.
- R3: `cntOut` increments by one on every observed SCL transition, rising or falling. When it wraps from 15 to 0, `ovfFlag` is set. A preset of 0 therefore overflows after 16 edges, and a preset of 14 overflows after 2 edges.
- R4: `sdaDrvLow` is high exactly when bit 7 of the shift register is 0. Loading 0xFF releases SDA, and loading 0x00 holds it low.
- R5: The SDA line level is captured at each observed SCL rise. At the following observed SCL fall, the register shifts left by one and the captured bit enters bit 0. A `wrData` load in the same cycle takes priority over the shift.
- R6: While `ovfFlag` is set, SCL falls do not shift the register. The counter keeps counting.
- R7: An SDA fall while SCL is high sets `startFlag`. An SDA rise while SCL is high sets `stopFlag`. SDA changes while SCL is low set neither flag.
- R8: `collFlag` is set when, at an observed SCL rise, bit 7 of the register is 1 (SDA released) but the SDA line reads low.
- R9: A `wrStat` cycle loads `cntPreset` into the counter. In the same cycle it clears each flag whose `statClr` bit is 1, using bit 0 for start, bit 1 for stop, bit 2 for overflow and bit 3 for collision. An event arriving in the same cycle sets its flag anyway. An SCL edge in that cycle is not counted.
- R10: While SCL is released but held low by another device, no edge is counted. The rise is counted only once the line actually goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Toggle the SCL drive |
| wrData | input | 1 | Load `wrVal` into the shift register |
| wrVal | input | DATA_W | Byte to load |
| wrStat | input | 1 | Status write: counter preset plus flag clear |
| statClr | input | 4 | Write-one-to-clear mask (0 start, 1 stop, 2 overflow, 3 collision) |
| cntPreset | input | CNT_W | Counter preset value |
| sclIn | input | 1 | Resolved SCL line level |
| sdaIn | input | 1 | Resolved SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| dataOut | output | DATA_W | Shift register contents |
| cntOut | output | CNT_W | Edge counter |
| startFlag | output | 1 | Start condition seen |
| stopFlag | output | 1 | Stop condition seen |
| ovfFlag | output | 1 | Counter wrapped |
| collFlag | output | 1 | Released SDA read low at an SCL rise |

## Verification
The bound checker watches several rules on every cycle. It checks that each strobe flips the SCL drive and that a status write lands its preset in the counter. It checks that a wrap from 15 always raises the overflow flag, that the register holds still once overflow is set and no load arrives, and that the start flag stays up until cleared. The bench scenarios are needed for the rest. Only they can show that a whole byte returns through the loop-back, that a one-bit preset yields an acknowledge bit, and that SDA moves while SCL is low raise no start or stop. They also show collision on a pulled-down released line and counting that waits for a stretched clock.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int NUM_FLAGS  = 4;
  localparam int FLAG_START = 0;
  localparam int FLAG_STOP  = 1;
  localparam int FLAG_OVF   = 2;
  localparam int FLAG_COLL  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;  // SCL rise seen: capture line level
    logic shift;   // SCL fall seen and shifting allowed
    logic bitIn;   // sampled SDA level
  } twsStrobe_t;
endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strobe,
  input  logic                 wrStat,
  input  logic [NUM_FLAGS-1:0] statClr,
  input  logic [CNT_W-1:0]     cntPreset,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 dataMsb,
  output logic                 sclDrvLow,
  output logic [CNT_W-1:0]     cnt,
  output logic [NUM_FLAGS-1:0] flags,
  output twsStrobe_t           strb
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic sclS, sclP, sdaS, sdaP, sclOut;
  logic sclRise, sclFall, sdaRise, sdaFall, sclHigh, anyEdge;
  logic [NUM_FLAGS-1:0] flagEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclS <= 1'b1;
      sclP <= 1'b1;
      sdaS <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclS <= sclIn;
      sclP <= sclS;
      sdaS <= sdaIn;
      sdaP <= sdaS;
    end
  end

  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign sdaRise = sdaS & ~sdaP;
  assign sdaFall = ~sdaS & sdaP;
  assign sclHigh = sclS & sclP;
  assign anyEdge = sclRise | sclFall;

  // SCL drive: one toggle per strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       sclOut <= 1'b1;
    else if (strobe) sclOut <= ~sclOut;
  end
  assign sclDrvLow = ~sclOut;

  // edge counter; the status write wins over an edge in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (wrStat)  cnt <= cntPreset;
    else if (anyEdge) cnt <= cnt + 1'b1;
  end

  always_comb begin
    flagEv             = '0;
    flagEv[FLAG_START] = sdaFall & sclHigh;
    flagEv[FLAG_STOP]  = sdaRise & sclHigh;
    flagEv[FLAG_OVF]   = ~wrStat & anyEdge & (cnt == CNT_TOP);
    flagEv[FLAG_COLL]  = sclRise & dataMsb & ~sdaS;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic flagBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagBit <= 1'b0;
      else       flagBit <= (flagBit & ~(wrStat & statClr[g])) | flagEv[g];
    end
    assign flags[g] = flagBit;
  end

  always_comb begin
    strb.sample = sclRise;
    strb.shift  = sclFall & ~flags[FLAG_OVF];
    strb.bitIn  = sdaS;
  end
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrVal,
  input  twsStrobe_t        strb,
  output logic [DATA_W-1:0] dataReg,
  output logic              dataMsb
);
  logic sampleBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sampleBit <= 1'b1;
    else if (strb.sample) sampleBit <= strb.bitIn;
  end

  // shifting on the SCL fall keeps SDA changes inside the low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataReg <= '1;
    else if (wrData)     dataReg <= wrVal;
    else if (strb.shift) dataReg <= {dataReg[DATA_W-2:0], sampleBit};
  end

  assign dataMsb = dataReg[DATA_W-1];
endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrVal,
  input  logic              wrStat,
  input  logic [3:0]        statClr,
  input  logic [CNT_W-1:0]  cntPreset,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              startFlag,
  output logic              stopFlag,
  output logic              ovfFlag,
  output logic              collFlag
);
  twsStrobe_t           strb;
  logic                 dataMsb;
  logic [NUM_FLAGS-1:0] flags;

  tws_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrStat(wrStat),
    .statClr(statClr), .cntPreset(cntPreset), .sclIn(sclIn), .sdaIn(sdaIn),
    .dataMsb(dataMsb), .sclDrvLow(sclDrvLow), .cnt(cntOut), .flags(flags),
    .strb(strb)
  );

  tws_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrVal(wrVal), .strb(strb),
    .dataReg(dataOut), .dataMsb(dataMsb)
  );

  assign sdaDrvLow = ~dataMsb;
  assign startFlag = flags[FLAG_START];
  assign stopFlag  = flags[FLAG_STOP];
  assign ovfFlag   = flags[FLAG_OVF];
  assign collFlag  = flags[FLAG_COLL];
endmodule

// File: rtl/tws_shift_unit_chk.sv
module tws_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              strobe,
  input logic              wrData,
  input logic              wrStat,
  input logic              clrStart,
  input logic [CNT_W-1:0]  cntPreset,
  input logic              sclDrvLow,
  input logic [DATA_W-1:0] dataOut,
  input logic [CNT_W-1:0]  cntOut,
  input logic              startFlag,
  input logic              ovfFlag
);
  assert_scl_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> (sclDrvLow != $past(sclDrvLow)));

  assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStat && cntOut == '1) |=> (cntOut != '0 || ovfFlag));

  assert_no_shift_after_ovf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !wrData) |=> $stable(dataOut));

  assert_start_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startFlag && !(wrStat && clrStart)) |=> startFlag);

  assert_preset_loads_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> (cntOut == $past(cntPreset)));
endmodule

bind tws_shift_unit tws_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrStat(wrStat),
  .clrStart(statClr[0]), .cntPreset(cntPreset), .sclDrvLow(sclDrvLow),
  .dataOut(dataOut), .cntOut(cntOut), .startFlag(startFlag), .ovfFlag(ovfFlag)
);

// File: tb/tb_tws_shift_unit.sv
module tb_tws_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobe = 1'b0, wrData = 1'b0, wrStat = 1'b0;
  logic [7:0] wrVal = 8'h00;
  logic [3:0] statClr = 4'h0, cntPreset = 4'h0;
  logic slaveSclLow = 1'b0, slaveSdaLow = 1'b0;
  logic sclIn, sdaIn, sclDrvLow, sdaDrvLow, startFlag, stopFlag, ovfFlag, collFlag;
  logic [7:0] dataOut;
  logic [3:0] cntOut;

  // open-drain wired-AND bus
  assign sclIn = ~(sclDrvLow | slaveSclLow);
  assign sdaIn = ~(sdaDrvLow | slaveSdaLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_shift_unit dut (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .wrVal(wrVal),
    .wrStat(wrStat), .statClr(statClr), .cntPreset(cntPreset), .sclIn(sclIn),
    .sdaIn(sdaIn), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow), .dataOut(dataOut),
    .cntOut(cntOut), .startFlag(startFlag), .stopFlag(stopFlag), .ovfFlag(ovfFlag),
    .collFlag(collFlag)
  );

  // scoreboard item: which output, expected value, requirement number
  typedef struct { int sel; int exp; int req; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int S_DATA = 0, S_CNT = 1, S_START = 2, S_STOP = 3, S_OVF = 4,
                 S_COLL = 5, S_SCL = 6, S_SDA = 7;

  function automatic int actual(input int sel);
    case (sel)
      S_DATA:  return int'(dataOut);
      S_CNT:   return int'(cntOut);
      S_START: return int'(startFlag);
      S_STOP:  return int'(stopFlag);
      S_OVF:   return int'(ovfFlag);
      S_COLL:  return int'(collFlag);
      S_SCL:   return int'(sclDrvLow);
      default: return int'(sdaDrvLow);
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial forever begin
    @(negedge clk);
    while (sbq.size() != 0) begin
      item_t it;
      int act;
      it = sbq.pop_front();
      act = actual(it.sel);
      checks++;
      if (act != it.exp) begin
        fails++;
        $display("FAIL R%0d output %0d: actual %0h expected %0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input int exp, input int req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic load_data(input logic [7:0] v);
    wrData = 1'b1; wrVal = v; tick(1); wrData = 1'b0;
  endtask

  task automatic write_stat(input logic [3:0] clr, input logic [3:0] pre);
    wrStat = 1'b1; statClr = clr; cntPreset = pre; tick(1); wrStat = 1'b0;
  endtask

  task automatic scl_edge();
    strobe = 1'b1; tick(1); strobe = 1'b0; tick(3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL run limit: actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rxByte;
    rxByte = 8'h3C;
    tick(3); rstN = 1'b1; tick(1);
    // R1 reset state
    expect_val(S_DATA, 8'hFF, 1); expect_val(S_CNT, 0, 1); expect_val(S_SCL, 0, 1);
    expect_val(S_SDA, 0, 1); expect_val(S_START, 0, 1); expect_val(S_STOP, 0, 1);
    expect_val(S_OVF, 0, 1); expect_val(S_COLL, 0, 1);
    tick(1);

    // start: SDA low while SCL high (R4, R7)
    load_data(8'h7F); tick(3);
    expect_val(S_SDA, 1, 4); expect_val(S_START, 1, 7); expect_val(S_STOP, 0, 7);
    tick(1);
    scl_edge();                          // SCL low: one falling edge
    expect_val(S_SCL, 1, 2); expect_val(S_CNT, 1, 3);
    tick(1);
    write_stat(4'hF, 4'd0);              // R9 clear all, preset 0
    expect_val(S_CNT, 0, 9); expect_val(S_START, 0, 9);
    tick(1);

    // byte write 0xA5, loop-back through released bus (R3, R4, R5)
    load_data(8'hA5);
    expect_val(S_SDA, 0, 4);
    tick(1);
    for (int i = 0; i < 5; i++) scl_edge();
    expect_val(S_CNT, 5, 3);
    tick(1);
    for (int i = 0; i < 11; i++) scl_edge();
    expect_val(S_CNT, 0, 3); expect_val(S_OVF, 1, 3);
    expect_val(S_DATA, 8'hA5, 5); expect_val(S_COLL, 0, 8);
    tick(1);
    // R6 no shift after overflow, counter still counts
    slaveSdaLow = 1'b1; scl_edge(); scl_edge(); slaveSdaLow = 1'b0;
    expect_val(S_DATA, 8'hA5, 6); expect_val(S_CNT, 2, 6);
    tick(1);

    // single-bit ACK receive with preset 14 (R3, R5, R8)
    write_stat(4'hF, 4'd14); load_data(8'hFF);
    slaveSdaLow = 1'b1; tick(2);
    scl_edge();
    expect_val(S_CNT, 15, 3); expect_val(S_COLL, 1, 8); expect_val(S_START, 0, 7);
    tick(1);
    scl_edge();
    expect_val(S_CNT, 0, 3); expect_val(S_OVF, 1, 3); expect_val(S_DATA, 8'hFE, 5);
    tick(1);
    slaveSdaLow = 1'b0; tick(2);

    // byte read 0x3C, slave drives SDA only while SCL low (R5, R7, R8)
    write_stat(4'hF, 4'd0); load_data(8'hFF); tick(1);
    for (int b = 7; b >= 0; b--) begin
      slaveSdaLow = ~rxByte[b]; tick(2);
      scl_edge(); scl_edge();
    end
    slaveSdaLow = 1'b0; tick(2);
    expect_val(S_DATA, 8'h3C, 5); expect_val(S_OVF, 1, 3); expect_val(S_COLL, 1, 8);
    expect_val(S_START, 0, 7); expect_val(S_STOP, 0, 7);
    tick(1);

    // stop: SDA rise while SCL high (R7); driven-low rise is no collision (R8)
    write_stat(4'hF, 4'd0); load_data(8'h00); tick(2);
    scl_edge();
    expect_val(S_CNT, 1, 3); expect_val(S_COLL, 0, 8); expect_val(S_STOP, 0, 7);
    tick(1);
    load_data(8'hFF); tick(3);
    expect_val(S_STOP, 1, 7); expect_val(S_START, 0, 7);
    tick(1);

    // R9 preset without clearing, then a single flag clear
    write_stat(4'h0, 4'd3);
    expect_val(S_CNT, 3, 9); expect_val(S_STOP, 1, 9);
    tick(1);
    write_stat(4'h2, 4'd0);
    expect_val(S_STOP, 0, 9);
    tick(1);

    // R10 clock stretching
    scl_edge();
    write_stat(4'hF, 4'd0);
    slaveSclLow = 1'b1;
    scl_edge(); tick(5);
    expect_val(S_SCL, 0, 10); expect_val(S_CNT, 0, 10);
    tick(1);
    slaveSclLow = 1'b0; tick(3);
    expect_val(S_CNT, 1, 10);
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule